// File: doc/BRIEF.md
# Paged Address Translator

This block turns a 16-bit virtual address into a 15-bit physical address through a small page table held on chip. The virtual space of 64 KB is cut into sixteen 4 KB pages and the physical space of 32 KB into eight 4 KB frames. Each table entry holds a 3-bit frame number and a present flag. A lookup uses the upper four address bits to pick the entry and passes the lower twelve bits through unchanged as the offset.

A requester raises a valid strobe with a virtual address and, one clock later, receives either a physical address or a page-fault flag together with the number of the page that missed. A separate write port lets the fault handler retire a page (clear its present flag) and install a new frame for the missing page, after which the retried access translates normally. After reset no page is present, so every lookup faults until the table is filled.

Top module: `pager_xlate`

## Requirements
- R1: After reset every entry is absent: `rsp_valid` is 0 while reset is held, and any lookup made before the first table write returns a fault.
- R2: Each lookup asserted on `req_valid` at a clock edge yields `rsp_valid` = 1 after exactly that one edge; a cycle without a request gives `rsp_valid` = 0 in the following cycle.
- R3: For a present page, `rsp_paddr` = frame number × 4096 + offset and `rsp_fault` = 0 (e.g. page 5 on frame 3 maps 20500 to 12308; page 15 on frame 7 maps 0xFFFF to 32767).
- R4: The offset, virtual address bits [11:0], appears unchanged in `rsp_paddr[11:0]`; the page number is virtual bits [15:12] and the frame number occupies `rsp_paddr[14:12]`.
- R5: For an absent page, `rsp_fault` = 1, `rsp_paddr` = 0 and `rsp_page` carries the 4-bit page number of the request (the page number is given on every valid response).
- R6: A write with `wr_en` = 1 stores `wr_present` and `wr_frame` into entry `wr_page`; lookups from the next cycle on use the new entry.
- R7: A lookup in the same cycle as a write to its own entry uses the old entry content.
- R8: Clearing the present flag of a page makes later accesses to it fault, and the freed frame can be given to another page (page 8 on frame 1 maps 32780 to 4108).
- R9: While `rsp_valid` is 0, `rsp_fault` and `rsp_paddr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| wr_en | input | 1 | Table write strobe |
| wr_page | input | 4 | Entry to write |
| wr_present | input | 1 | Present flag to store |
| wr_frame | input | 3 | Frame number to store |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_fault | output | 1 | Page fault for this response |
| rsp_paddr | output | 15 | Physical address, 0 on a fault |
| rsp_page | output | 4 | Page number of the request |

## Verification
The bench goes after the eviction sequence, where a design that forgot to clear or re-read the present flag would still translate the retired page or keep faulting the newly installed one. It issues a lookup in the same cycle as a write to the same entry; a table read through the write path would return the new frame instead of the expected fault. It probes the top page with the all-ones address, where a carry or width slip in joining frame and offset would corrupt bit 14 or the offset, and checks that the faulting page number comes back so a swapped bit field would point the handler at the wrong entry.

// File: rtl/pager_pkg.sv
package pager_pkg;

    localparam int VA_W      = 16;
    localparam int OFF_W     = 12;
    localparam int FRAME_W   = 3;
    localparam int PAGE_W    = VA_W - OFF_W;
    localparam int PA_W      = FRAME_W + OFF_W;
    localparam int NUM_PAGES = 1 << PAGE_W;

    typedef logic [VA_W-1:0]    vaddr_t;
    typedef logic [PA_W-1:0]    paddr_t;
    typedef logic [PAGE_W-1:0]  page_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [OFF_W-1:0]   off_t;

    // One table entry
    typedef struct packed {
        logic   present;
        frame_t frame;
    } pte_t;

    // One translation result
    typedef struct packed {
        logic   fault;
        page_t  page;
        paddr_t paddr;
    } xlate_t;

    function automatic page_t page_of(input vaddr_t va);
        return va[VA_W-1:OFF_W];
    endfunction

    function automatic off_t off_of(input vaddr_t va);
        return va[OFF_W-1:0];
    endfunction

    // Frame base plus offset; frame is 4 KB aligned so this is a concatenation
    function automatic paddr_t join_addr(input frame_t f, input off_t o);
        return {f, o};
    endfunction

endpackage

// File: rtl/pager_table.sv
module pager_table
    import pager_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  page_t wr_page,
    input  pte_t  wr_entry,
    input  page_t rd_page,
    output pte_t  rd_entry
);

    pte_t entries [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[g] <= '0;
            end else if (wr_en && (wr_page == page_t'(g))) begin
                entries[g] <= wr_entry;
            end
        end
    end

    // Read sees the pre-edge content, so a same-cycle write is not visible
    assign rd_entry = entries[rd_page];

endmodule

// File: rtl/pager_core.sv
module pager_core
    import pager_pkg::*;
(
    input  vaddr_t vaddr,
    input  pte_t   entry,
    output xlate_t result
);

    always_comb begin
        result.page = page_of(vaddr);
        if (entry.present) begin
            result.fault = 1'b0;
            result.paddr = join_addr(entry.frame, off_of(vaddr));
        end else begin
            result.fault = 1'b1;
            result.paddr = '0;
        end
    end

endmodule

// File: rtl/pager_resp.sv
module pager_resp
    import pager_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  xlate_t in_result,
    output logic   out_valid,
    output xlate_t out_result
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= in_valid;
            out_result <= in_valid ? in_result : '0;
        end
    end

endmodule

// File: rtl/pager_xlate.sv
module pager_xlate
    import pager_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic              wr_present,
    input  logic [FRAME_W-1:0] wr_frame,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [PAGE_W-1:0] rsp_page
);

    pte_t   wr_entry;
    pte_t   rd_entry;
    xlate_t comb_result;
    xlate_t reg_result;

    assign wr_entry.present = wr_present;
    assign wr_entry.frame   = wr_frame;

    pager_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_page  (wr_page),
        .wr_entry (wr_entry),
        .rd_page  (page_of(req_vaddr)),
        .rd_entry (rd_entry)
    );

    pager_core u_core (
        .vaddr  (req_vaddr),
        .entry  (rd_entry),
        .result (comb_result)
    );

    pager_resp u_resp (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (req_valid),
        .in_result  (comb_result),
        .out_valid  (rsp_valid),
        .out_result (reg_result)
    );

    assign rsp_fault = reg_result.fault;
    assign rsp_paddr = reg_result.paddr;
    assign rsp_page  = reg_result.page;

endmodule

// File: rtl/pager_xlate_chk.sv
module pager_xlate_chk
    import pager_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              wr_en,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [PAGE_W-1:0] rsp_page
);

    logic armed;
    logic written;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            written <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (wr_en) written <= 1'b1;
        end
    end

    assert_empty_table_R1: assert property (@(posedge clk) disable iff (rst)
        (!written && rsp_valid) |-> rsp_fault);

    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        armed |-> (rsp_valid == $past(req_valid)));

    assert_offset_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    assert_fault_page_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && rsp_valid) |-> (rsp_page == $past(req_vaddr[VA_W-1:OFF_W])));

    assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_fault && rsp_paddr == '0));

endmodule

bind pager_xlate pager_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .wr_en     (wr_en),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr),
    .rsp_page  (rsp_page)
);

// File: tb/pager_xlate_bench.sv
`timescale 1ns/1ps
module pager_xlate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_page = '0;
    logic        wr_present = 1'b0;
    logic [2:0]  wr_frame = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [14:0] rsp_paddr;
    logic [3:0]  rsp_page;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pager_xlate u_pager_xlate (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .wr_en      (wr_en),
        .wr_page    (wr_page),
        .wr_present (wr_present),
        .wr_frame   (wr_frame),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_paddr  (rsp_paddr),
        .rsp_page   (rsp_page)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic map_page(input int page, input bit present, input int frame);
        @(negedge clk);
        wr_en = 1'b1; wr_page = 4'(page); wr_present = present; wr_frame = 3'(frame);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue one lookup and check the response in the following cycle
    task automatic lookup(input string req, input int va, input bit exp_fault, input int exp_pa);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 16'(va);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, "rsp_valid", int'(rsp_valid), 1);
        check(req, "rsp_fault", int'(rsp_fault), int'(exp_fault));
        check(req, "rsp_paddr", int'(rsp_paddr), exp_fault ? 0 : exp_pa);
        check(req, "rsp_page", int'(rsp_page), va >> 12);
    endtask

    task automatic t_reset;
        check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
        @(negedge clk); rst = 1'b0;
        lookup("R1", 0, 1'b1, 0);
        lookup("R1", 16'hFFFF, 1'b1, 0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R2", "rsp_valid idle", int'(rsp_valid), 0);
        check("R9", "rsp_fault idle", int'(rsp_fault), 0);
        check("R9", "rsp_paddr idle", int'(rsp_paddr), 0);
    endtask

    task automatic t_basic_map;
        map_page(0, 1'b1, 2);
        map_page(2, 1'b1, 6);
        map_page(5, 1'b1, 3);
        lookup("R6", 0, 1'b0, 8192);
        lookup("R4", 1026, 1'b0, 9218);
        lookup("R3", 8192, 1'b0, 24576);
        lookup("R4", 8196, 1'b0, 24580);
        lookup("R3", 20500, 1'b0, 12308);
    endtask

    task automatic t_top_page;
        map_page(15, 1'b1, 7);
        lookup("R3", 16'hFFFF, 1'b0, 32767);
        lookup("R4", 16'hF000, 1'b0, 28672);
    endtask

    task automatic t_fault;
        lookup("R5", 32780, 1'b1, 0);
        lookup("R5", 16'h9ABC, 1'b1, 0);
    endtask

    task automatic t_evict;
        map_page(1, 1'b1, 1);
        lookup("R8", 4096 + 7, 1'b0, 4103);
        map_page(1, 1'b0, 0);
        map_page(8, 1'b1, 1);
        lookup("R8", 32780, 1'b0, 4108);
        lookup("R8", 4096, 1'b1, 0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_page = 4'd7; wr_present = 1'b1; wr_frame = 3'd4;
        req_valid = 1'b1; req_vaddr = 16'h7ABC;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R7", "old entry faults", int'(rsp_fault), 1);
        check("R7", "rsp_paddr", int'(rsp_paddr), 0);
        lookup("R7", 16'h7ABC, 1'b0, 4 * 4096 + 16'hABC);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 16'd20480;
        @(negedge clk);
        req_vaddr = 16'd32768;
        check("R2", "first valid", int'(rsp_valid), 1);
        check("R2", "first paddr", int'(rsp_paddr), 12288);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "second valid", int'(rsp_valid), 1);
        check("R2", "second paddr", int'(rsp_paddr), 4096);
        @(negedge clk);
        check("R2", "drop valid", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_idle();
        t_basic_map();
        t_top_page();
        t_fault();
        t_evict();
        t_same_cycle();
        t_back_to_back();
        t_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule